// File: doc/BRIEF.md
# Spread-Spectrum Coefficient Embedder

This block hides a small watermark in the transform coefficients of one 8x8 image block. Coefficients arrive one per cycle as signed 16-bit words with a valid flag. One pseudo-noise code of 64 chips belongs to each watermark bit, and each code adds to or subtracts from every coefficient a code chip of plus or minus one, scaled by an unsigned modulation index. All the codes are laid on the same 64 coefficients. The watermarked coefficient leaves the block one cycle after it enters. The result is clamped to the signed 16-bit range.

Each code comes from a 6-bit maximal-length shift register. A zero chip is added at the front of each frame, so a 63-step sequence fills 64 coefficients. The codes for bits that are 0 are summed in one group and the codes for bits that are 1 in the other. The embedder adds the difference between the two groups, times the index, to each coefficient. A frame strobe reloads every register from its stored seed and takes in the watermark bits and the index for the new frame, so a detector that holds the same seeds can regenerate the codes exactly. New seeds can be written at any time. They take effect at the next frame strobe.

Top module: `ssw_embedder`

## Requirements
- R1: After a reset, `emb_valid` and `emb_data` are 0. The watermark context is cleared (bits 0, index 0), so coefficients pass through unchanged until the first frame strobe. Stored seed i is ((13*i+5) mod 63)+1, which gives 6, 19, 32, 45.
- R2: `emb_valid` is `coef_valid` delayed by one cycle. When it is low, `emb_data` is 0.
- R3: Each code register steps with new = {s[0]^s[1], s[5:1]} and emits chip s[0]. It moves only on a valid coefficient whose index is not 0. Its state is never zero.
- R4: Coefficient index 0 of a frame is the first valid coefficient at or after the strobe. At index 0 every code emits a 0 chip and no register steps. Indices 1 to 63 use the registers. The index wraps to 0 after 64 valid coefficients, and the pad is then inserted again.
- R5: `frame_start` reloads all registers from the stored seeds and sets the index to 0. A coefficient valid in that same cycle is index 0 of the new frame.
- R6: A chip of 1 counts as +1 and a chip of 0 counts as -1.
- R7: The weight is the sum of the mapped chips of the codes whose watermark bit is 0, minus the sum for the codes whose bit is 1. The output is coefficient + index * weight. With an index of 0 the coefficient is unchanged.
- R8: The output saturates at 32767 and -32768 instead of wrapping.
- R9: `seed_wr` stores seed i from `seed_bus[6i+5:6i]`, and a written zero is stored as 1. New seeds are used from the next strobe onward, never by the running frame or by a strobe in the same cycle.
- R10: `wm_bits` and `mod_k` are sampled only at `frame_start`. Changes between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame strobe: reload codes, capture context |
| seed_wr | input | 1 | Write all stored seeds |
| seed_bus | input | 24 | Seed values, 6 bits per code, code 0 lowest |
| wm_bits | input | 4 | Watermark bits, bit i drives code i |
| mod_k | input | 8 | Unsigned modulation index |
| coef_valid | input | 1 | Coefficient present |
| coef_data | input | 16 | Signed input coefficient |
| emb_valid | output | 1 | Watermarked coefficient present |
| emb_data | output | 16 | Signed watermarked coefficient |

## Verification
Assertions check several properties on every cycle. Each code register is nonzero and holds when it does not step. The summed weight stays within plus or minus four and has the parity of the code count. Idle cycles produce a zero output, and clamping occurs whenever the wide sum leaves the 16-bit range. The frame index restarts correctly at a strobe and holds without traffic. Other behaviour can only be shown by a bench model run through whole frames: the exact chip sequences, the leading pad and the wrap at 64, seeds that take effect only at the next strobe, and a watermark context that ignores mid-frame changes.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int SSW_NUM_BITS = 4;
    localparam int SSW_LFSR_W   = 6;
    localparam int SSW_DATA_W   = 16;
    localparam int SSW_K_W      = 8;

    // chip slot within a frame: leading pad or register-driven
    typedef enum logic {
        PH_PAD  = 1'b0,
        PH_CODE = 1'b1
    } chip_phase_e;

    // reset seed for code idx, never zero
    function automatic logic [SSW_LFSR_W-1:0] default_seed(input int idx);
        return SSW_LFSR_W'((((idx * 13) + 5) % 63) + 1);
    endfunction

endpackage

// File: rtl/ssw_lfsr.sv
module ssw_lfsr #(
    parameter int             W        = 6,
    parameter logic [W-1:0]   RST_SEED = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    input  logic [W-1:0] seed,
    input  logic         advance,
    output logic         chip
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_eff;
    logic [W-1:0] state_nxt;

    always_comb begin
        state_eff = reload ? seed : state_q;
        chip      = state_eff[0];
        state_nxt = advance ? {state_eff[0] ^ state_eff[1], state_eff[W-1:1]} : state_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RST_SEED;
        else     state_q <= state_nxt;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R3

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reload && !advance) |=> $stable(state_q)); // R3

endmodule

// File: rtl/ssw_code_mix.sv
module ssw_code_mix #(
    parameter int NB    = 4,
    parameter int WGT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NB-1:0]           chips,
    input  logic [NB-1:0]           wm,
    output logic signed [WGT_W-1:0] weight
);

    localparam logic signed [WGT_W-1:0] PLUS_ONE  = WGT_W'(1);
    localparam logic signed [WGT_W-1:0] MINUS_ONE = -WGT_W'(1);

    logic signed [WGT_W-1:0] grp_zero;
    logic signed [WGT_W-1:0] grp_one;

    always_comb begin
        grp_zero = '0;
        grp_one  = '0;
        for (int i = 0; i < NB; i++) begin
            if (wm[i]) grp_one  = grp_one  + (chips[i] ? PLUS_ONE : MINUS_ONE);
            else       grp_zero = grp_zero + (chips[i] ? PLUS_ONE : MINUS_ONE);
        end
        weight = grp_zero - grp_one;
    end

    AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (weight <= NB) && (weight >= -NB)); // R7

    AST_WEIGHT_PARITY: assert property (@(posedge clk) disable iff (rst)
        weight[0] == 1'(NB % 2)); // R6

endmodule

// File: rtl/ssw_embed_sat.sv
module ssw_embed_sat #(
    parameter int DATA_W = 16,
    parameter int K_W    = 8,
    parameter int WGT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic [K_W-1:0]           k,
    input  logic signed [WGT_W-1:0]  weight,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int PROD_W = WGT_W + K_W + 1;
    localparam int SUM_W  = ((DATA_W > PROD_W) ? DATA_W : PROD_W) + 1;
    localparam logic signed [SUM_W-1:0]  MAX_S = SUM_W'((1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0]  MIN_S = -SUM_W'(1 <<< (DATA_W - 1));
    localparam logic signed [DATA_W-1:0] MAX_D = MAX_S[DATA_W-1:0];
    localparam logic signed [DATA_W-1:0] MIN_D = MIN_S[DATA_W-1:0];

    logic signed [K_W:0]        k_s;
    logic signed [PROD_W-1:0]   prod;
    logic signed [SUM_W-1:0]    sum;
    logic signed [DATA_W-1:0]   sat;

    always_comb begin
        k_s  = $signed({1'b0, k});
        prod = PROD_W'(weight) * PROD_W'(k_s);
        sum  = SUM_W'(in_data) + SUM_W'(prod);
        if (sum > MAX_S)      sat = MAX_D;
        else if (sum < MIN_S) sat = MIN_D;
        else                  sat = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_valid ? sat : '0;
        end
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sum > MAX_S)) |=> (out_data == MAX_D)); // R8

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sum < MIN_S)) |=> (out_data == MIN_D)); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && (out_data == '0))); // R2

    AST_K_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (k == '0)) |=> (out_data == $past(in_data))); // R7

endmodule

// File: rtl/ssw_embedder.sv
module ssw_embedder
    import ssw_pkg::*;
#(
    parameter int NUM_BITS = SSW_NUM_BITS,
    parameter int LFSR_W   = SSW_LFSR_W,
    parameter int DATA_W   = SSW_DATA_W,
    parameter int K_W      = SSW_K_W,
    localparam int SEED_BUS_W = NUM_BITS * LFSR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic                     seed_wr,
    input  logic [SEED_BUS_W-1:0]    seed_bus,
    input  logic [NUM_BITS-1:0]      wm_bits,
    input  logic [K_W-1:0]           mod_k,
    input  logic                     coef_valid,
    input  logic signed [DATA_W-1:0] coef_data,
    output logic                     emb_valid,
    output logic signed [DATA_W-1:0] emb_data
);

    localparam int IDX_W = LFSR_W;
    localparam int WGT_W = $clog2(NUM_BITS + 1) + 1;

    logic [NUM_BITS-1:0][LFSR_W-1:0] seed_q;
    logic [NUM_BITS-1:0]             wm_q, wm_eff;
    logic [K_W-1:0]                  k_q, k_eff;
    logic [IDX_W-1:0]                idx_q, idx_eff;
    chip_phase_e                     phase;
    logic [NUM_BITS-1:0]             chips_raw, chips_used;
    logic                            step_en;
    logic signed [WGT_W-1:0]         weight;

    // frame context: strobe wins over stored values in its own cycle
    always_comb begin
        wm_eff     = frame_start ? wm_bits : wm_q;
        k_eff      = frame_start ? mod_k   : k_q;
        idx_eff    = frame_start ? '0      : idx_q;
        phase      = (idx_eff == '0) ? PH_PAD : PH_CODE;
        step_en    = coef_valid && (phase == PH_CODE);
        chips_used = (phase == PH_PAD) ? '0 : chips_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q  <= '0;
            k_q   <= '0;
            idx_q <= '0;
        end else begin
            wm_q  <= wm_eff;
            k_q   <= k_eff;
            idx_q <= coef_valid ? idx_eff + IDX_W'(1) : idx_eff;
        end
    end

    for (genvar g = 0; g < NUM_BITS; g++) begin : g_code
        localparam logic [LFSR_W-1:0] RST_SEED = LFSR_W'(default_seed(g));
        logic [LFSR_W-1:0] wr_val;

        assign wr_val = seed_bus[g*LFSR_W +: LFSR_W];

        always_ff @(posedge clk) begin
            if (rst)          seed_q[g] <= RST_SEED;
            else if (seed_wr) seed_q[g] <= (wr_val == '0) ? LFSR_W'(1) : wr_val;
        end

        ssw_lfsr #(
            .W        (LFSR_W),
            .RST_SEED (RST_SEED)
        ) u_lfsr (
            .clk     (clk),
            .rst     (rst),
            .reload  (frame_start),
            .seed    (seed_q[g]),
            .advance (step_en),
            .chip    (chips_raw[g])
        );

        AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
            seed_q[g] != '0); // R9
    end

    ssw_code_mix #(
        .NB    (NUM_BITS),
        .WGT_W (WGT_W)
    ) u_mix (
        .clk    (clk),
        .rst    (rst),
        .chips  (chips_used),
        .wm     (wm_eff),
        .weight (weight)
    );

    ssw_embed_sat #(
        .DATA_W (DATA_W),
        .K_W    (K_W),
        .WGT_W  (WGT_W)
    ) u_embed (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (coef_valid),
        .in_data   (coef_data),
        .k         (k_eff),
        .weight    (weight),
        .out_valid (emb_valid),
        .out_data  (emb_data)
    );

    AST_STROBE_IDX_VALID: assert property (@(posedge clk) disable iff (rst)
        (frame_start && coef_valid) |=> (idx_q == IDX_W'(1))); // R5

    AST_STROBE_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !coef_valid) |=> (idx_q == '0)); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !coef_valid) |=> $stable(idx_q)); // R4

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(wm_q) && $stable(k_q))); // R10

endmodule

// File: tb/tb_ssw_embedder.sv
module tb_ssw_embedder;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        seed_wr;
    logic [23:0] seed_bus;
    logic [3:0]  wm_bits;
    logic [7:0]  mod_k;
    logic        coef_valid;
    logic signed [15:0] coef_data;
    logic        emb_valid;
    logic signed [15:0] emb_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    int m_seed[4];
    int m_state[4];
    int m_idx;
    int m_wm;
    int m_k;
    bit    have_pend = 0;
    bit    pend_valid;
    int    pend_data;
    string pend_tag;

    always #10 clk = ~clk;

    ssw_embedder dut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .seed_wr     (seed_wr),
        .seed_bus    (seed_bus),
        .wm_bits     (wm_bits),
        .mod_k       (mod_k),
        .coef_valid  (coef_valid),
        .coef_data   (coef_data),
        .emb_valid   (emb_valid),
        .emb_data    (emb_data)
    );

    function automatic int lfsr_next(input int s);
        return ((((s & 1) ^ ((s >> 1) & 1)) << 5) | (s >> 1)) & 63;
    endfunction

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check_pending();
        int got;
        got = int'(emb_data);
        checks++;
        if (emb_valid !== pend_valid || got != pend_data) begin
            failures++;
            $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
                     pend_tag, emb_valid, got, pend_valid, pend_data);
        end
    endtask

    task automatic cyc(input bit v, input int d, input bit fs, input bit swr,
                       input logic [23:0] sbus, input int wm, input int k, input string tag);
        int w;
        int chip;
        @(negedge clk);
        if (have_pend) check_pending();
        coef_valid  = v;
        coef_data   = 16'(d);
        frame_start = fs;
        seed_wr     = swr;
        seed_bus    = sbus;
        wm_bits     = 4'(wm);
        mod_k       = 8'(k);
        if (fs) begin
            for (int i = 0; i < 4; i++) m_state[i] = m_seed[i];
            m_idx = 0;
            m_wm  = wm & 15;
            m_k   = k & 255;
        end
        pend_data = 0;
        if (v) begin
            w = 0;
            for (int i = 0; i < 4; i++) begin
                chip = (m_idx == 0) ? 0 : (m_state[i] & 1);
                if ((m_wm >> i) & 1) w -= (chip != 0) ? 1 : -1;
                else                 w += (chip != 0) ? 1 : -1;
            end
            pend_data = clamp16(d + m_k * w);
            if (m_idx != 0)
                for (int i = 0; i < 4; i++) m_state[i] = lfsr_next(m_state[i]);
            m_idx = (m_idx + 1) % 64;
        end
        if (swr)
            for (int i = 0; i < 4; i++) begin
                m_seed[i] = int'(sbus[i*6 +: 6]);
                if (m_seed[i] == 0) m_seed[i] = 1;
            end
        pend_valid = v;
        pend_tag   = tag;
        have_pend  = 1;
    endtask

    function automatic int rnd_data();
        return int'($urandom_range(65535)) - 32768;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int len;
        int wm;
        int k;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        frame_start = 0; seed_wr = 0; seed_bus = '0; wm_bits = '0; mod_k = '0;
        coef_valid = 0; coef_data = '0;
        for (int i = 0; i < 4; i++) m_seed[i] = (((i * 13) + 5) % 63) + 1;
        for (int i = 0; i < 4; i++) m_state[i] = m_seed[i];
        m_idx = 0; m_wm = 0; m_k = 0;

        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (emb_valid !== 1'b0 || emb_data !== 16'sd0) begin
                failures++;
                $display("FAIL R1 reset: got valid=%0b data=%0d, expected 0 0", emb_valid, emb_data);
            end
        end
        @(negedge clk);
        rst = 1'b0;

        // R1 pass-through before any strobe, with k=0 context
        for (int n = 0; n < 8; n++) cyc(1, rnd_data(), 0, 0, '0, 15, 200, "R1 passthrough");

        // default seeds, zero data: output shows the weight (R3 R4 R6), wrap past 64
        for (int n = 0; n < 70; n++)
            cyc(1, 0, n == 0, 0, '0, 0, 1, "R3/R4/R6 default codes");

        // gaps in valid, mixed bits (R2 R3 R7)
        for (int n = 0; n < 150; n++)
            cyc($urandom_range(9) < 7, int'($urandom_range(2000)) - 1000, n == 0, 0, '0,
                4'b1010, 3, "R2/R3/R7 gapped stream");

        // strobe with no valid coefficient, then data (R5)
        cyc(0, 0, 1, 0, '0, 4'b0110, 7, "R5 idle strobe");
        for (int n = 0; n < 10; n++) cyc(1, 100, 0, 0, '0, 0, 0, "R5 after idle strobe");

        // context changes between strobes are ignored (R10)
        for (int n = 0; n < 40; n++)
            cyc(1, rnd_data() / 4, 0, 0, '0, int'($urandom_range(15)), int'($urandom_range(255)),
                "R10 context held");

        // seed write mid-frame, one zero seed; strobe in same cycle uses old seeds (R9)
        cyc(1, 0, 0, 1, {6'd33, 6'd17, 6'd0, 6'd9}, 0, 0, "R9 seed write");
        for (int n = 0; n < 20; n++) cyc(1, 0, 0, 0, '0, 0, 0, "R9 running frame");
        for (int n = 0; n < 70; n++)
            cyc(1, 0, n == 0, n == 0, {6'd63, 6'd63, 6'd63, 6'd63}, 4'b0011, 2,
                "R9 new seeds applied");
        for (int n = 0; n < 66; n++)
            cyc(1, 0, n == 0, 0, '0, 4'b1001, 5, "R9 later seeds applied");

        // saturation at both rails (R8)
        for (int n = 0; n < 32; n++) cyc(1, 32767, n == 0, 0, '0, 0, 255, "R8 high rail");
        for (int n = 0; n < 32; n++) cyc(1, -32768, n == 0, 0, '0, 15, 255, "R8 low rail");
        for (int n = 0; n < 32; n++) cyc(1, 32000, n == 0, 0, '0, 4'b0101, 255, "R8 mixed rail");

        // random frames (R2 R4 R5 R7)
        for (int f = 0; f < 30; f++) begin
            len = int'($urandom_range(90)) + 1;
            wm  = int'($urandom_range(15));
            k   = int'($urandom_range(255));
            for (int n = 0; n < len; n++)
                cyc($urandom_range(9) < 8, rnd_data(), n == 0, $urandom_range(19) == 0,
                    24'($urandom), wm, k, "R2/R4/R5/R7 random frame");
        end

        cyc(0, 0, 0, 0, '0, 0, 0, "R2 flush");
        @(negedge clk);
        check_pending();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule